// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block captures stereo PCM words from two serial data lines that share one bit clock and one left/right framing clock. The clocks and data arrive asynchronously to the block's system clock. They are synchronised and then oversampled, and each rising edge of the bit clock becomes a single-cycle bit tick. Control inputs select the framing and the word length. The framing can be I2S, left-justified or right-justified. The word length can be 16, 18, 20 or 24 bits. The bit clock may run at 32, 48 or 64 times the frame rate.

Each data line has its own capture lane, and one shared controller tracks the slot boundaries and the bit position within a slot. Output words are always 24 bits wide and left-aligned, with the unused low bits zero. The first data line delivers a left and a right word. The second data line delivers only its left word, and its right slot is discarded. A one-cycle strobe marks each completed frame. A flag reports configurations that cannot be captured.

Top module: `serial_audio_rx`

## Requirements
- R1: With `fmtSel`=00 (I2S), a slot is left when `lrClk` is low. The MSB is sampled on the second rising bit-clock edge after `lrClk` changes level, one bit-clock period after the change.
- R2: With `fmtSel`=01 (left-justified), a slot is left when `lrClk` is high. The MSB is sampled on the first rising bit-clock edge at which the new `lrClk` level is seen.
- R3: With `fmtSel`=10 (right-justified), a slot is left when `lrClk` is high. The word is the last N bits sampled before the next `lrClk` change, MSB first, whatever the slot length.
- R4: `wlenSel` 00/01/10/11 selects N = 16/18/20/24. The output word carries the N received bits in bits 23 down to 24-N. The bits below that are zero, and data bits outside the N-bit window have no effect.
- R5: `fmtSel`=11 is reserved. It raises `fmtUnsupported` and produces no `sampleValid`.
- R6: Slots of 16, 24 and 32 bit clocks (32, 48 and 64 times fs) are captured correctly. This includes I2S at 16 bits in a 16-bit slot, where the LSB falls on the first edge of the following slot.
- R7: `sampleValid` is a one-cycle pulse raised after a right slot completes, once the slot boundary that follows it is seen. The output words change only on that pulse and hold their values between pulses.
- R8: `pairLeft` and `pairRight` carry the left and right words of `sdIn0`. `subLeft` carries the left word of `sdIn1`, and the right slot of `sdIn1` has no effect on any output.
- R9: Right-justified 24-bit capture with a measured slot shorter than 24 bit clocks (32 times fs) raises `fmtUnsupported` and suppresses `sampleValid`. A 24-bit slot or longer leaves the flag low.
- R10: After reset, all output words are zero and `sampleValid` is low. A partial slot that is already in progress when capture starts never produces a `sampleValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than 4x the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bitClk | input | 1 | Serial bit clock, asynchronous |
| lrClk | input | 1 | Left/right framing clock, asynchronous |
| sdIn0 | input | 1 | Serial data, stereo line |
| sdIn1 | input | 1 | Serial data, line whose left word only is used |
| fmtSel | input | 2 | 00 I2S, 01 left-justified, 10 right-justified, 11 reserved |
| wlenSel | input | 2 | 00 16-bit, 01 18-bit, 10 20-bit, 11 24-bit |
| pairLeft | output | 24 | Left word of sdIn0, left-aligned |
| pairRight | output | 24 | Right word of sdIn0, left-aligned |
| subLeft | output | 24 | Left word of sdIn1, left-aligned |
| sampleValid | output | 1 | One-cycle pulse when a frame is complete |
| fmtUnsupported | output | 1 | Configuration cannot be captured |

## Verification
The hardest case to reach is a word that straddles a slot boundary. This happens with I2S at 16 bits in a 16-bit slot, where the LSB of one channel is sampled after `lrClk` has already switched to the other channel. Reaching it requires a driver that delays the data stream by exactly one bit relative to `lrClk`. The bench builds each slot as an ideal MSB-first stream, shifts it by one bit for I2S, and fills every bit position outside the word window with ones, so that masking faults show up at the outputs. It also starts every run with a short partial slot, which exposes any frame emitted before a full left and right pair has been captured.

// File: rtl/arx_pkg.sv
package arx_pkg;

  localparam int IDX_W = 7;

  localparam logic [1:0] FMT_I2S  = 2'b00;
  localparam logic [1:0] FMT_LJ   = 2'b01;
  localparam logic [1:0] FMT_RJ   = 2'b10;
  localparam logic [1:0] FMT_RSVD = 2'b11;

  // Per-tick control strobes from the slot tracker to each capture lane
  typedef struct packed {
    logic             tick;       // rising bit-clock edge seen
    logic             slotStart;  // this tick opens a new slot
    logic             capEn;      // this bit lies inside the word window
    logic             commitLeft; // previous slot was a left word
    logic             emit;       // previous slot was right; publish frame
    logic             isRJ;       // right-justified capture path
    logic [IDX_W-1:0] bitIdx;     // position of this bit within its slot
  } arx_strobe_t;

  function automatic logic [IDX_W-1:0] wordLen(input logic [1:0] code);
    case (code)
      2'b00:   return IDX_W'(16);
      2'b01:   return IDX_W'(18);
      2'b10:   return IDX_W'(20);
      default: return IDX_W'(24);
    endcase
  endfunction

endpackage

// File: rtl/arx_sync.sv
module arx_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[s] <= '0;
      else     pipe[s] <= pipe[s-1];
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/arx_ctrl.sv
module arx_ctrl
  import arx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sclkS,
  input  logic        lrS,
  input  logic [1:0]  fmtSel,
  input  logic [1:0]  wlenSel,
  output arx_strobe_t st,
  output logic        sampleValid,
  output logic        fmtUnsupported
);

  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic             sclkPrev;
  logic             lrDly;
  logic             effPrev;
  logic [1:0]       startCnt;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] lastIdx;
  logic             primed;
  logic             leftSeen;
  logic             validQ;

  logic             tick;
  logic             isI2S;
  logic             effLr;
  logic             slotStart;
  logic             prevLeft;
  logic [IDX_W-1:0] nextIdx;
  logic             unsup;

  assign tick     = sclkS & ~sclkPrev;
  assign isI2S    = (fmtSel == FMT_I2S);
  // I2S data trails the framing clock by one bit: track a delayed copy
  assign effLr    = isI2S ? lrDly : lrS;
  assign slotStart = tick && (startCnt == 2'd2) && (effLr != effPrev);
  assign prevLeft  = isI2S ? ~effPrev : effPrev;

  always_comb begin
    if (slotStart)              nextIdx = '0;
    else if (bitIdx == IDX_MAX) nextIdx = bitIdx;
    else                        nextIdx = bitIdx + 1'b1;
  end

  assign unsup = (fmtSel == FMT_RSVD) ||
                 ((fmtSel == FMT_RJ) && (wlenSel == 2'b11) &&
                  (lastIdx < IDX_W'(23)));

  always_comb begin
    st.tick       = tick;
    st.slotStart  = slotStart;
    st.capEn      = tick && (fmtSel != FMT_RJ) && (nextIdx < wordLen(wlenSel));
    st.commitLeft = slotStart && primed && prevLeft;
    st.emit       = slotStart && primed && !prevLeft && leftSeen && !unsup;
    st.isRJ       = (fmtSel == FMT_RJ);
    st.bitIdx     = nextIdx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclkPrev <= 1'b0;
      lrDly    <= 1'b0;
      effPrev  <= 1'b0;
      startCnt <= '0;
      bitIdx   <= '0;
      lastIdx  <= '1;
      primed   <= 1'b0;
      leftSeen <= 1'b0;
      validQ   <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      validQ   <= st.emit;
      if (tick) begin
        lrDly   <= lrS;
        effPrev <= effLr;
        bitIdx  <= nextIdx;
        if (startCnt != 2'd2) startCnt <= startCnt + 1'b1;
      end
      if (slotStart) begin
        primed  <= 1'b1;
        lastIdx <= bitIdx;
      end
      if (st.commitLeft)                    leftSeen <= 1'b1;
      else if (slotStart && primed && !prevLeft) leftSeen <= 1'b0;
    end
  end

  assign sampleValid    = validQ;
  assign fmtUnsupported = unsup;

  // R7: frame strobe lasts one cycle
  p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> !sampleValid);

  // R7: a frame strobe always follows a bit tick that closed a slot
  p_valid_after_tick_r7: assert property (@(posedge clk) disable iff (rst)
    sampleValid |-> $past(tick));

  // R9: a steady unsupported configuration never publishes
  p_unsup_mute_r9: assert property (@(posedge clk) disable iff (rst)
    (fmtUnsupported && $stable(fmtUnsupported)) |-> !sampleValid);

endmodule

// File: rtl/arx_lane.sv
module arx_lane
  import arx_pkg::*;
#(
  parameter int SAMPLE_W   = 24,
  parameter bit KEEP_RIGHT = 1'b1,
  localparam int OUT_W     = KEEP_RIGHT ? 2 * SAMPLE_W : SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  arx_strobe_t       st,
  input  logic [1:0]        wlenSel,
  input  logic              dIn,
  output logic [OUT_W-1:0]  outWord
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(SAMPLE_W - 1);
  localparam logic [IDX_W-1:0] FULL_W  = IDX_W'(SAMPLE_W);

  logic [SAMPLE_W-1:0] shiftReg;
  logic [SAMPLE_W-1:0] word;
  logic [SAMPLE_W-1:0] holdL;
  logic [SAMPLE_W-1:0] outL;

  logic [IDX_W-1:0]    nBits;
  logic [SAMPLE_W-1:0] keepMask;
  logic [SAMPLE_W-1:0] rjWord;
  logic [SAMPLE_W-1:0] commitVal;
  logic [IDX_W-1:0]    wrIdx;

  assign nBits     = wordLen(wlenSel);
  assign keepMask  = ~({SAMPLE_W{1'b1}} >> nBits);
  assign rjWord    = shiftReg << (FULL_W - nBits);
  assign commitVal = (st.isRJ ? rjWord : word) & keepMask;
  assign wrIdx     = TOP_IDX - st.bitIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      word     <= '0;
      holdL    <= '0;
      outL     <= '0;
    end else begin
      if (st.tick) begin
        shiftReg <= {shiftReg[SAMPLE_W-2:0], dIn};
        if (st.slotStart)  word <= {dIn, {(SAMPLE_W-1){1'b0}}};
        else if (st.capEn) word[wrIdx] <= dIn;
      end
      if (st.commitLeft) holdL <= commitVal;
      if (st.emit)       outL  <= holdL;
    end
  end

  if (KEEP_RIGHT) begin : g_stereo
    logic [SAMPLE_W-1:0] outR;
    always_ff @(posedge clk) begin
      if (rst)          outR <= '0;
      else if (st.emit) outR <= commitVal;
    end
    assign outWord = {outL, outR};

    // R4: published right word has nothing below the word window
    p_right_low_zero_r4: assert property (@(posedge clk) disable iff (rst)
      (st.emit && $stable(wlenSel)) |=> ((outR & ~keepMask) == '0));
  end else begin : g_mono
    assign outWord = outL;
  end

  // R4: published left word has nothing below the word window
  p_left_low_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (st.emit && $stable(wlenSel)) |=> ((outL & ~keepMask) == '0));

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import arx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bitClk,
  input  logic                lrClk,
  input  logic                sdIn0,
  input  logic                sdIn1,
  input  logic [1:0]          fmtSel,
  input  logic [1:0]          wlenSel,
  output logic [SAMPLE_W-1:0] pairLeft,
  output logic [SAMPLE_W-1:0] pairRight,
  output logic [SAMPLE_W-1:0] subLeft,
  output logic                sampleValid,
  output logic                fmtUnsupported
);

  logic [3:0]  rawIn;
  logic [3:0]  syncIn;
  arx_strobe_t strobes;
  logic [2*SAMPLE_W-1:0] pairWord;

  assign rawIn = {bitClk, lrClk, sdIn1, sdIn0};

  arx_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .din (rawIn),
    .dout(syncIn)
  );

  arx_ctrl ctrl_i (
    .clk           (clk),
    .rst           (rst),
    .sclkS         (syncIn[3]),
    .lrS           (syncIn[2]),
    .fmtSel        (fmtSel),
    .wlenSel       (wlenSel),
    .st            (strobes),
    .sampleValid   (sampleValid),
    .fmtUnsupported(fmtUnsupported)
  );

  arx_lane #(.SAMPLE_W(SAMPLE_W), .KEEP_RIGHT(1'b1)) lanePair_i (
    .clk    (clk),
    .rst    (rst),
    .st     (strobes),
    .wlenSel(wlenSel),
    .dIn    (syncIn[0]),
    .outWord(pairWord)
  );

  arx_lane #(.SAMPLE_W(SAMPLE_W), .KEEP_RIGHT(1'b0)) laneSub_i (
    .clk    (clk),
    .rst    (rst),
    .st     (strobes),
    .wlenSel(wlenSel),
    .dIn    (syncIn[1]),
    .outWord(subLeft)
  );

  assign pairLeft  = pairWord[2*SAMPLE_W-1:SAMPLE_W];
  assign pairRight = pairWord[SAMPLE_W-1:0];

endmodule

// File: tb/serial_audio_rx_tb_top.sv
`timescale 1ns/1ps
module serial_audio_rx_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        bitClk, lrClk, sdIn0, sdIn1;
  logic [1:0]  fmtSel, wlenSel;
  logic [23:0] pairLeft, pairRight, subLeft;
  logic        sampleValid, fmtUnsupported;

  always #2.5 clk = ~clk;

  serial_audio_rx dut_i (
    .clk(clk), .rst(rst), .bitClk(bitClk), .lrClk(lrClk),
    .sdIn0(sdIn0), .sdIn1(sdIn1), .fmtSel(fmtSel), .wlenSel(wlenSel),
    .pairLeft(pairLeft), .pairRight(pairRight), .subLeft(subLeft),
    .sampleValid(sampleValid), .fmtUnsupported(fmtUnsupported)
  );

  typedef struct {
    logic [23:0] l;
    logic [23:0] r;
    logic [23:0] s;
    string       tag;
  } exp_t;

  exp_t        expQ[$];
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 0;
  logic [31:0] seed   = 32'h1234_5678;
  int          curN, curS;
  bit          curI2S, curRJ;
  logic        prev0, prev1;
  logic [23:0] lastL;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [23:0] nextRand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed[23:0];
  endfunction

  // monitor: compare every published frame against the scoreboard
  always @(negedge clk) begin
    if (!rst && sampleValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R7", "unexpected sampleValid", 24'h1, 24'h0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(pairLeft  == e.l, e.tag, "pairLeft",  pairLeft,  e.l);
        check(pairRight == e.r, e.tag, "pairRight", pairRight, e.r);
        check(subLeft   == e.s, {e.tag, "/R8"}, "subLeft", subLeft, e.s);
      end
    end
  end

  task automatic bitOut(input logic lr, input logic d0, input logic d1);
    @(negedge clk);
    bitClk = 1'b0; lrClk = lr; sdIn0 = d0; sdIn1 = d1;
    repeat (3) @(negedge clk);
    bitClk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic effBit(input logic [23:0] w, input int p);
    if (curRJ) return (p >= curS - curN) ? w[curS - 1 - p] : 1'b1;
    return (p < curN) ? w[curN - 1 - p] : 1'b1;
  endfunction

  task automatic sendSlot(input logic lr, input logic [23:0] w0,
                          input logic [23:0] w1, input int len);
    int saveS;
    saveS = curS;
    curS  = len;
    for (int p = 0; p < len; p++) begin
      logic e0, e1, d0, d1;
      e0 = effBit(w0, p);
      e1 = effBit(w1, p);
      if (curI2S) begin
        d0 = prev0; d1 = prev1; prev0 = e0; prev1 = e1;
      end else begin
        d0 = e0; d1 = e1;
      end
      bitOut(lr, d0, d1);
    end
    curS = saveS;
  endtask

  task automatic doReset();
    rst = 1'b1; bitClk = 1'b0; lrClk = 1'b0; sdIn0 = 1'b0; sdIn1 = 1'b0;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic runCase(input logic [1:0] fmt, input logic [1:0] wl,
                         input int slotLen, input int frames,
                         input bit expectOut, input string tag);
    logic leftLv;
    doReset();
    fmtSel = fmt; wlenSel = wl;
    curN   = (wl == 2'b00) ? 16 : (wl == 2'b01) ? 18 : (wl == 2'b10) ? 20 : 24;
    curI2S = (fmt == 2'b00);
    curRJ  = (fmt == 2'b10);
    curS   = slotLen;
    leftLv = curI2S ? 1'b0 : 1'b1;
    prev0 = 1'b1; prev1 = 1'b1;
    // partial slot in the right-channel level before the first full frame (R10)
    sendSlot(~leftLv, 24'hFFFFFF, 24'hFFFFFF, 4);
    for (int f = 0; f < frames; f++) begin
      logic [23:0] l0, r0, l1, r1, msk;
      exp_t e;
      msk = 24'hFFFFFF >> (24 - curN);
      l0 = nextRand() & msk; r0 = nextRand() & msk;
      l1 = nextRand() & msk; r1 = nextRand() & msk;
      if (expectOut) begin
        e.l = l0 << (24 - curN); e.r = r0 << (24 - curN);
        e.s = l1 << (24 - curN); e.tag = tag;
        expQ.push_back(e);
        lastL = e.l;
      end
      sendSlot(leftLv, l0, l1, slotLen);
      sendSlot(~leftLv, r0, r1, slotLen);
    end
    sendSlot(leftLv, 24'h0, 24'h0, 4);
    repeat (20) @(negedge clk);
    check(expQ.size() == 0, tag, "frames not published",
          24'(expQ.size()), 24'h0);
    expQ.delete();
  endtask

  initial begin
    fmtSel = 2'b00; wlenSel = 2'b11;
    doReset();
    // R10: reset state
    check(pairLeft == 24'h0,  "R10", "reset pairLeft",  pairLeft,  24'h0);
    check(pairRight == 24'h0, "R10", "reset pairRight", pairRight, 24'h0);
    check(subLeft == 24'h0,   "R10", "reset subLeft",   subLeft,   24'h0);
    check(sampleValid == 1'b0, "R10", "reset sampleValid", 24'(sampleValid), 24'h0);

    runCase(2'b00, 2'b11, 32, 3, 1'b1, "R1");        // I2S 24-bit, 64 fs
    runCase(2'b00, 2'b00, 16, 3, 1'b1, "R6");        // I2S 16-bit, 32 fs: LSB crosses boundary
    runCase(2'b01, 2'b01, 24, 3, 1'b1, "R2/R4");     // LJ 18-bit, 48 fs
    runCase(2'b01, 2'b10, 32, 2, 1'b1, "R2/R4");     // LJ 20-bit, 64 fs
    runCase(2'b10, 2'b00, 32, 2, 1'b1, "R3");        // RJ 16-bit, 64 fs
    runCase(2'b10, 2'b10, 24, 2, 1'b1, "R3/R4");     // RJ 20-bit, 48 fs
    runCase(2'b10, 2'b11, 24, 2, 1'b1, "R3/R6");     // RJ 24-bit, 48 fs
    check(fmtUnsupported == 1'b0, "R9", "flag with 24-bit slot",
          24'(fmtUnsupported), 24'h0);
    // R7: outputs hold the last frame after the strobe
    check(pairLeft == lastL, "R7", "held pairLeft", pairLeft, lastL);

    runCase(2'b10, 2'b11, 16, 2, 1'b0, "R9");        // RJ 24-bit, 32 fs: unsupported
    check(fmtUnsupported == 1'b1, "R9", "flag with 16-bit slot",
          24'(fmtUnsupported), 24'h1);

    runCase(2'b11, 2'b00, 32, 2, 1'b0, "R5");        // reserved format
    check(fmtUnsupported == 1'b1, "R5", "reserved format flag",
          24'(fmtUnsupported), 24'h1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule